// File: doc/BRIEF.md
# FIQ/IRQ Steering Interrupt Controller

The block gathers 200 interrupt request lines and folds them into two processor inputs: a fast interrupt (FIQ) and a normal interrupt (IRQ). Every source is first brought into the clock domain by a two-stage synchronizer. It is then conditioned by a per-source polarity bit and a per-source detection mode (level or edge). It is then gated by a per-source enable and steered by a per-source route bit to one of the two outputs.

Edge-mode sources are held in a sticky pending flop until software clears them through a write-only clear bank. Software can read back two status banks: the enabled pending sources steered to FIQ, and those steered to IRQ. Each output is the registered OR of its status bank.

Software uses a 32-bit register bus with a one-cycle write strobe and a read request whose data appears on the following cycle. Every bank holds seven words. Word w of a bank covers sources 32*w up to 32*w+31, and in the seventh word only bits 7:0 are used.

Top module: `irq_steer`

## Requirements
- R1: After reset every route bit is 1 (IRQ), and every enable, polarity and mode bit is 0. Route words 0 to 5 read 0xFFFFFFFF, route word 6 reads 0x000000FF, and fiq_o and irq_o are 0.
- R2: The word address is bank*8 + word. The bank codes are mode=0, polarity=1, route=2, enable=3, clear=4, FIQ status=5, IRQ status=6. Word 7 of any bank, bank 7, and the write-only clear bank read 0. Read data is presented on the cycle after the read request and is 0 on every other cycle.
- R3: A polarity bit of 0 makes its source active when high. A polarity bit of 1 makes it active when low.
- R4: A mode bit of 0 selects level detection. The pending state then follows the synchronized, polarity-corrected input, and writes to the clear bank do not change it.
- R5: A mode bit of 1 selects edge detection. An inactive-to-active transition, even one lasting a single cycle, sets a pending bit that stays set after the input returns.
- R6: Writing 1 to a clear-bank bit clears the pending bit of the matching edge-mode source. Writing 0 leaves it unchanged.
- R7: If an edge event and a clear of the same source land in the same cycle, the pending bit ends up set.
- R8: An enable bit of 0 removes its source from both status banks and from both outputs. An enable bit of 1 lets it through.
- R9: A route bit of 0 steers an enabled pending source to the FIQ status bank and fiq_o. A route bit of 1 steers it to the IRQ status bank and irq_o. No source appears in both banks.
- R10: fiq_o and irq_o are the registered OR of their status banks. A level-mode source that changes at src_i reaches the output three clock edges later: two synchronizer stages plus the output register.
- R11: Bits 31:8 of word 6 in every bank read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 200 | Interrupt request lines, asynchronous |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read request |
| bus_addr_i | input | 6 | Word address: bank in bits 5:3, word in bits 2:0 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after bus_rd_i |
| fiq_o | output | 1 | Fast interrupt request, registered |
| irq_o | output | 1 | Normal interrupt request, registered |

## Verification
The visible failure of a corrupted pending flop depends on its cause. A missed or doubled edge latch shows up as a wrong status-bank bit on the next read, and as a wrong fiq_o or irq_o level one cycle after the pending flop updates. A bad enable or route bit shows up immediately as a source placed in the wrong status bank, or in both. A wrong number of synchronizer stages shows up only as a shifted output edge, so the latency check samples the output on each of the three edges that follow an input change. A clear that wrongly wins over a simultaneous edge leaves a pending bit at 0; this is visible one read later and never recovers until the next edge.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    localparam int NUM_SRC     = 200;
    localparam int WORD_W      = 32;
    localparam int NUM_WORDS   = (NUM_SRC + WORD_W - 1) / WORD_W;
    localparam int PAD_W       = NUM_WORDS * WORD_W;
    localparam int WORD_IDX_W  = $clog2(NUM_WORDS + 1);
    localparam int BANK_W      = 3;
    localparam int ADDR_W      = BANK_W + WORD_IDX_W;
    localparam int SYNC_STAGES = 2;
    localparam int NUM_CFG     = 4;

    typedef enum logic [BANK_W-1:0] {
        BANK_MODE     = 3'd0,
        BANK_POL      = 3'd1,
        BANK_ROUTE    = 3'd2,
        BANK_ENABLE   = 3'd3,
        BANK_CLEAR    = 3'd4,
        BANK_FIQ_STAT = 3'd5,
        BANK_IRQ_STAT = 3'd6,
        BANK_NONE     = 3'd7
    } bank_e;

    typedef struct packed {
        bank_e                 bank;
        logic [WORD_IDX_W-1:0] word;
    } bus_addr_t;

    typedef struct packed {
        logic [NUM_SRC-1:0] edge_mode;
        logic [NUM_SRC-1:0] low_active;
        logic [NUM_SRC-1:0] to_irq;
        logic [NUM_SRC-1:0] enable;
    } src_cfg_t;

    // Reset level of each configuration bank; only the route bank starts at 1.
    function automatic logic cfg_reset_bit(input int bank);
        return (bank == int'(BANK_ROUTE));
    endfunction

    // Extract one 32-bit word of a source vector; words past the end read 0.
    function automatic logic [WORD_W-1:0] get_word(
        input logic [NUM_SRC-1:0]    vec,
        input logic [WORD_IDX_W-1:0] idx
    );
        logic [PAD_W-1:0]  padded;
        logic [WORD_W-1:0] res;
        padded              = '0;
        padded[NUM_SRC-1:0] = vec;
        res                 = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (idx == WORD_IDX_W'(w)) res = padded[w*WORD_W +: WORD_W];
        end
        return res;
    endfunction

    // Replace one word of a source vector; bits past the last source are dropped.
    function automatic logic [NUM_SRC-1:0] put_word(
        input logic [NUM_SRC-1:0]    vec,
        input logic [WORD_IDX_W-1:0] idx,
        input logic [WORD_W-1:0]     data
    );
        logic [PAD_W-1:0] padded;
        padded              = '0;
        padded[NUM_SRC-1:0] = vec;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (idx == WORD_IDX_W'(w)) padded[w*WORD_W +: WORD_W] = data;
        end
        return padded[NUM_SRC-1:0];
    endfunction

endpackage

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
    import irq_steer_pkg::*;
#(
    parameter logic RST_BIT = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en_i,
    input  logic [WORD_IDX_W-1:0] word_i,
    input  logic [WORD_W-1:0]     wdata_i,
    output logic [NUM_SRC-1:0]    bits_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_o <= {NUM_SRC{RST_BIT}};
        end else if (wr_en_i) begin
            bits_o <= put_word(bits_o, word_i, wdata_i);
        end
    end

endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond
    import irq_steer_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_SRC-1:0]    src_i,
    input  logic [NUM_SRC-1:0]    edge_mode_i,
    input  logic [NUM_SRC-1:0]    low_active_i,
    input  logic                  clr_en_i,
    input  logic [WORD_IDX_W-1:0] clr_word_i,
    input  logic [WORD_W-1:0]     clr_data_i,
    output logic [NUM_SRC-1:0]    pend_o
);

    logic [NUM_SRC-1:0] sync_q [SYNC_STAGES];
    logic [NUM_SRC-1:0] active;
    logic [NUM_SRC-1:0] active_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] edge_pend_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= '0;
        else     sync_q[0] <= src_i;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : gen_sync
        always_ff @(posedge clk) begin
            if (rst) sync_q[s] <= '0;
            else     sync_q[s] <= sync_q[s-1];
        end
    end

    always_comb begin
        active  = sync_q[SYNC_STAGES-1] ^ low_active_i;
        rise    = active & ~active_q;
        clr_vec = clr_en_i ? put_word('0, clr_word_i, clr_data_i) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q    <= '0;
            edge_pend_q <= '0;
        end else begin
            active_q    <= active;
            // A new edge overrides a clear landing in the same cycle.
            edge_pend_q <= edge_mode_i & (rise | (edge_pend_q & ~clr_vec));
        end
    end

    assign pend_o = (edge_mode_i & edge_pend_q) | (~edge_mode_i & active);

endmodule

// File: rtl/irq_steer.sv
module irq_steer
    import irq_steer_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [WORD_W-1:0]  bus_wdata_i,
    output logic [WORD_W-1:0]  bus_rdata_o,
    output logic               fiq_o,
    output logic               irq_o
);

    bus_addr_t          addr;
    logic [NUM_SRC-1:0] cfg_bits [NUM_CFG];
    src_cfg_t           cfg;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] fiq_stat;
    logic [NUM_SRC-1:0] irq_stat;
    logic [NUM_SRC-1:0] mask_bits;
    logic [WORD_W-1:0]  rd_mux;

    assign addr = bus_addr_i;

    for (genvar b = 0; b < NUM_CFG; b++) begin : gen_cfg
        irq_cfg_bank #(
            .RST_BIT (cfg_reset_bit(b))
        ) i_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en_i (bus_wr_i && (addr.bank == BANK_W'(b))),
            .word_i  (addr.word),
            .wdata_i (bus_wdata_i),
            .bits_o  (cfg_bits[b])
        );
    end

    always_comb begin
        cfg.edge_mode  = cfg_bits[int'(BANK_MODE)];
        cfg.low_active = cfg_bits[int'(BANK_POL)];
        cfg.to_irq     = cfg_bits[int'(BANK_ROUTE)];
        cfg.enable     = cfg_bits[int'(BANK_ENABLE)];
    end

    irq_src_cond i_cond (
        .clk          (clk),
        .rst          (rst),
        .src_i        (src_i),
        .edge_mode_i  (cfg.edge_mode),
        .low_active_i (cfg.low_active),
        .clr_en_i     (bus_wr_i && (addr.bank == BANK_CLEAR)),
        .clr_word_i   (addr.word),
        .clr_data_i   (bus_wdata_i),
        .pend_o       (pend)
    );

    assign mask_bits = cfg.enable;
    assign fiq_stat  = pend & cfg.enable & ~cfg.to_irq;
    assign irq_stat  = pend & cfg.enable &  cfg.to_irq;

    always_comb begin
        unique case (addr.bank)
            BANK_MODE:     rd_mux = get_word(cfg.edge_mode,  addr.word);
            BANK_POL:      rd_mux = get_word(cfg.low_active, addr.word);
            BANK_ROUTE:    rd_mux = get_word(cfg.to_irq,     addr.word);
            BANK_ENABLE:   rd_mux = get_word(cfg.enable,     addr.word);
            BANK_FIQ_STAT: rd_mux = get_word(fiq_stat,       addr.word);
            BANK_IRQ_STAT: rd_mux = get_word(irq_stat,       addr.word);
            default:       rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata_o <= '0;
            fiq_o       <= 1'b0;
            irq_o       <= 1'b0;
        end else begin
            bus_rdata_o <= bus_rd_i ? rd_mux : '0;
            fiq_o       <= |fiq_stat;
            irq_o       <= |irq_stat;
        end
    end

endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk
    import irq_steer_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_rd_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [WORD_W-1:0]  bus_rdata_o,
    input logic               fiq_o,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] fiq_stat,
    input logic [NUM_SRC-1:0] irq_stat,
    input logic [NUM_SRC-1:0] mask_bits
);

    localparam int TAIL_BITS = NUM_SRC - (NUM_WORDS - 1) * WORD_W;

    logic [WORD_IDX_W-1:0] word_sel;
    logic [BANK_W-1:0]     bank_sel;
    assign word_sel = bus_addr_i[WORD_IDX_W-1:0];
    assign bank_sel = bus_addr_i[ADDR_W-1:WORD_IDX_W];

    assert_route_disjoint_R9: assert property (@(posedge clk) disable iff (rst)
        (fiq_stat & irq_stat) == '0);

    assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        ((fiq_stat | irq_stat) & ~mask_bits) == '0);

    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && ((int'(word_sel) >= NUM_WORDS) || (bank_sel == BANK_W'(7))
                      || (bank_sel == BANK_W'(BANK_CLEAR))))
        |=> (bus_rdata_o == '0));

    assert_idle_rdata_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_i |=> (bus_rdata_o == '0));

    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && (int'(word_sel) == NUM_WORDS - 1))
        |=> (bus_rdata_o[WORD_W-1:TAIL_BITS] == '0));

    assert_fiq_follows_R10: assert property (@(posedge clk) disable iff (rst)
        (|fiq_stat) |=> fiq_o);

    assert_fiq_drops_R10: assert property (@(posedge clk) disable iff (rst)
        !(|fiq_stat) |=> !fiq_o);

    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
        (|irq_stat) |=> irq_o);

    assert_irq_drops_R10: assert property (@(posedge clk) disable iff (rst)
        !(|irq_stat) |=> !irq_o);

endmodule

bind irq_steer irq_steer_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .fiq_o       (fiq_o),
    .irq_o       (irq_o),
    .fiq_stat    (fiq_stat),
    .irq_stat    (irq_stat),
    .mask_bits   (mask_bits)
);

// File: tb/test_irq_steer.sv
module test_irq_steer;
    import irq_steer_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic [NUM_SRC-1:0] src;
    logic               wr;
    logic               rd;
    logic [ADDR_W-1:0]  addr;
    logic [WORD_W-1:0]  wdata;
    logic [WORD_W-1:0]  rdata;
    logic               fiq;
    logic               irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_steer i_irq_steer (
        .clk         (clk),
        .rst         (rst),
        .src_i       (src),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .fiq_o       (fiq),
        .irq_o       (irq)
    );

    task automatic check(input string req, input string what,
                         input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(input bank_e b, input int w);
        return {b, WORD_IDX_W'(w)};
    endfunction

    task automatic wr_word(input bank_e b, input int w, input logic [WORD_W-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = mk_addr(b, w); wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_word(input bank_e b, input int w, output logic [WORD_W-1:0] d);
        @(negedge clk);
        rd = 1'b1; addr = mk_addr(b, w);
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic wr_bank(input bank_e b, input logic [NUM_SRC-1:0] v);
        for (int w = 0; w < NUM_WORDS; w++) wr_word(b, w, get_word(v, WORD_IDX_W'(w)));
    endtask

    task automatic check_bank(input string req, input bank_e b, input logic [NUM_SRC-1:0] v);
        logic [WORD_W-1:0] d;
        for (int w = 0; w < NUM_WORDS; w++) begin
            rd_word(b, w, d);
            check(req, $sformatf("bank %0d word %0d", b, w), d, get_word(v, WORD_IDX_W'(w)));
        end
    endtask

    function automatic logic [NUM_SRC-1:0] rand_vec();
        logic [PAD_W-1:0] p;
        for (int w = 0; w < NUM_WORDS; w++) p[w*WORD_W +: WORD_W] = $urandom;
        return p[NUM_SRC-1:0];
    endfunction

    // Pending state expected after a single step from s_old to s_new, starting with nothing latched.
    function automatic logic [NUM_SRC-1:0] exp_pend(
        input logic [NUM_SRC-1:0] s_old, input logic [NUM_SRC-1:0] s_new,
        input logic [NUM_SRC-1:0] mode,  input logic [NUM_SRC-1:0] pol);
        logic [NUM_SRC-1:0] a_old, a_new;
        a_old = s_old ^ pol;
        a_new = s_new ^ pol;
        return (mode & a_new & ~a_old) | (~mode & a_new);
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [WORD_W-1:0]  d;
        logic [NUM_SRC-1:0] ones;
        void'($urandom(32'd4711));
        ones = '1;
        rst = 1'b1; src = '0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1: reset state
        check("R1", "fiq_o after reset", 32'(fiq), 32'd0);
        check("R1", "irq_o after reset", 32'(irq), 32'd0);
        check_bank("R1", BANK_ROUTE,  ones);
        check_bank("R1", BANK_ENABLE, '0);
        check_bank("R1", BANK_MODE,   '0);
        check_bank("R1", BANK_POL,    '0);

        // R2: unmapped words, unmapped bank, write-only clear bank, idle data
        rd_word(BANK_ROUTE, 7, d);   check("R2", "route word 7", d, 32'd0);
        rd_word(BANK_NONE, 0, d);    check("R2", "bank 7", d, 32'd0);
        rd_word(BANK_CLEAR, 0, d);   check("R2", "clear bank read", d, 32'd0);
        idle(1);                     check("R2", "rdata idle", rdata, 32'd0);

        // R11: reserved upper bits of the last word
        wr_word(BANK_ENABLE, NUM_WORDS - 1, 32'hFFFF_FFFF);
        rd_word(BANK_ENABLE, NUM_WORDS - 1, d);
        check("R11", "enable word 6 after all-ones write", d, 32'h0000_00FF);
        wr_word(BANK_ENABLE, NUM_WORDS - 1, 32'h0);

        // R10 / R9: level source 5 to FIQ, latency from src_i
        wr_word(BANK_ENABLE, 0, 32'h20);
        wr_word(BANK_ROUTE, 0, 32'hFFFF_FFDF);
        idle(2);
        src[5] = 1'b1;
        @(negedge clk); check("R10", "fiq after 1 edge", 32'(fiq), 32'd0);
        @(negedge clk); check("R10", "fiq after 2 edges", 32'(fiq), 32'd0);
        @(negedge clk); check("R10", "fiq after 3 edges", 32'(fiq), 32'd1);
        check("R9", "irq while routed to FIQ", 32'(irq), 32'd0);
        rd_word(BANK_FIQ_STAT, 0, d); check("R9", "fiq status word 0", d, 32'h20);
        rd_word(BANK_IRQ_STAT, 0, d); check("R9", "irq status word 0", d, 32'h0);

        // R9: steer to IRQ
        wr_word(BANK_ROUTE, 0, 32'hFFFF_FFFF);
        idle(2);
        check("R9", "irq after reroute", 32'(irq), 32'd1);
        check("R9", "fiq after reroute", 32'(fiq), 32'd0);
        rd_word(BANK_IRQ_STAT, 0, d); check("R9", "irq status after reroute", d, 32'h20);

        // R8: disable blocks the source
        wr_word(BANK_ENABLE, 0, 32'h0);
        idle(2);
        check("R8", "irq with enable 0", 32'(irq), 32'd0);
        rd_word(BANK_IRQ_STAT, 0, d); check("R8", "irq status with enable 0", d, 32'h0);
        wr_word(BANK_ENABLE, 0, 32'h20);
        idle(2);
        check("R8", "irq with enable 1", 32'(irq), 32'd1);

        // R3: low-active polarity
        wr_word(BANK_POL, 0, 32'h20);
        idle(2);
        check("R3", "low-active with input high", 32'(irq), 32'd0);
        src[5] = 1'b0;
        idle(4);
        check("R3", "low-active with input low", 32'(irq), 32'd1);
        wr_word(BANK_POL, 0, 32'h0);
        idle(2);
        check("R3", "high-active with input low", 32'(irq), 32'd0);

        // R4: level source ignores clear and follows its input
        src[5] = 1'b1;
        idle(4);
        wr_word(BANK_CLEAR, 0, 32'h20);
        idle(2);
        check("R4", "level after clear write", 32'(irq), 32'd1);
        rd_word(BANK_IRQ_STAT, 0, d); check("R4", "level status after clear", d, 32'h20);
        src[5] = 1'b0;
        idle(4);
        check("R4", "level follows input low", 32'(irq), 32'd0);

        // R5: edge mode, single-cycle pulse latched
        wr_word(BANK_MODE, 0, 32'h20);
        idle(2);
        @(negedge clk); src[5] = 1'b1;
        @(negedge clk); src[5] = 1'b0;
        idle(5);
        check("R5", "edge pulse latched", 32'(irq), 32'd1);
        rd_word(BANK_IRQ_STAT, 0, d); check("R5", "edge status", d, 32'h20);

        // R6: clear with 0 keeps, with 1 clears
        wr_word(BANK_CLEAR, 0, 32'h0);
        idle(2);
        check("R6", "clear write of 0", 32'(irq), 32'd1);
        wr_word(BANK_CLEAR, 0, 32'h20);
        idle(2);
        check("R6", "clear write of 1", 32'(irq), 32'd0);
        rd_word(BANK_IRQ_STAT, 0, d); check("R6", "status after clear", d, 32'h0);

        // R7: edge and clear in the same cycle, edge wins
        @(negedge clk); src[5] = 1'b1;
        @(negedge clk);
        @(negedge clk); wr = 1'b1; addr = mk_addr(BANK_CLEAR, 0); wdata = 32'h20;
        @(negedge clk); wr = 1'b0; wdata = '0;
        idle(3);
        check("R7", "set wins over clear", 32'(irq), 32'd1);
        src[5] = 1'b0;
        wr_word(BANK_CLEAR, 0, 32'h20);
        wr_word(BANK_MODE, 0, 32'h0);
        wr_word(BANK_ENABLE, 0, 32'h0);
        idle(3);

        // Random configurations: R3 R4 R5 R8 R9 R10
        for (int it = 0; it < 20; it++) begin
            logic [NUM_SRC-1:0] s1, s2, mode, pol, rte, en, pend;
            s1   = rand_vec();
            s2   = s1 ^ (rand_vec() & rand_vec());
            mode = rand_vec();
            pol  = rand_vec();
            rte  = rand_vec();
            en   = (it % 4 == 0) ? rand_vec() & rand_vec() & rand_vec() : rand_vec();
            src  = s1;
            idle(4);
            wr_bank(BANK_MODE, mode);
            wr_bank(BANK_POL, pol);
            wr_bank(BANK_ROUTE, rte);
            wr_bank(BANK_ENABLE, en);
            idle(4);
            wr_bank(BANK_CLEAR, ones);
            idle(4);
            src = s2;
            idle(6);
            pend = exp_pend(s1, s2, mode, pol);
            check_bank("R9", BANK_FIQ_STAT, pend & en & ~rte);
            check_bank("R9", BANK_IRQ_STAT, pend & en & rte);
            check("R10", "random fiq_o", 32'(fiq), 32'(|(pend & en & ~rte)));
            check("R10", "random irq_o", 32'(irq), 32'(|(pend & en & rte)));
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule